// File: doc/BRIEF.md
# Oversampled Serial Receiver with Ninth-Bit Address Filter

This block recovers asynchronous serial characters from a single input line. An external oversampling tick paces it: either 16 or 4 ticks make up one bit time. A falling edge on the idle line starts a frame. The block samples each bit near its centre and assembles one of two character types: an 8-bit character, with even, odd or no parity, or a 9-bit character. Parity and stop-bit faults travel with each character. Completed characters go into a four-entry queue that software drains through a head-of-queue read port.

Two modes serve multi-drop links. In address-filter mode, 9-bit characters whose top bit is 0 are thrown away, and software leaves the mode once it sees its own address. The input polarity can be flipped for lines that idle low. The interrupt output follows the queue fill level against one of three thresholds. Once the queue has overflowed, a sticky overrun flag freezes the receive path until software acknowledges it.

Top module: `uart_rx_addr`

## Requirements
- R1: Tick 0 is the first tick that sees the normalised line low, and bit k spans ticks k·N to k·N+N−1. With `cfg_fast`=0 (N=16), bit k takes the majority of the line at ticks k·16+7, +8 and +9 and is decided at +9. With `cfg_fast`=1 (N=4), bit k is the single sample at tick k·4+2. If the start bit decides 1, the frame is abandoned and nothing is stored.
- R2: `cfg_fmt` selects the frame. 00 is 8 data bits without parity, 01 is 8 bits with even parity, 10 is 8 bits with odd parity, and 11 is 9 data bits. Data arrives LSB first. In 8-bit formats `rd_data[8]` reads 0.
- R3: `rd_perr` is 1 for the head character when its parity bit breaks the selected even or odd rule. It is always 0 in formats 00 and 11.
- R4: `rd_ferr` is 1 for the head character when its stop bit was decided 0. The character is still stored.
- R5: The queue holds 4 characters in arrival order. A character appears on the outputs just after the clock edge of its stop-bit decision tick. `rd_data`, `rd_perr` and `rd_ferr` show the oldest character, `data_avail` is 1 while the queue is non-empty, and `rd_en` removes the head on the next edge.
- R6: When a character completes on the same edge where `rd_en` pops a full queue, the character is stored and no overrun is raised.
- R7: A character that completes with the queue full and no pop is lost and sets `ovf`. While `ovf` is 1, every completed character is lost. `clr_ovf` clears the flag.
- R8: `irq` is 1 when the fill level is at least 1 for `cfg_isel` 00 or 01, at least 3 for 10, and equal to 4 for 11.
- R9: With `cfg_fmt`=11 and `cfg_addr_en`=1, a character whose bit 8 is 0 is discarded without touching the queue or `ovf`. With `cfg_addr_en`=0, all characters are accepted.
- R10: With `cfg_inv`=1, the line is inverted before sampling, so the idle level is 0.
- R11: `idle` is 1 exactly when no frame is in progress. It falls on the start-detection edge and rises on the stop-bit or false-start decision edge.
- R12: The receiver only advances on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line |
| tick | input | 1 | Oversampling enable, one clock wide |
| cfg_fast | input | 1 | 1: 4 ticks per bit, 0: 16 ticks per bit |
| cfg_fmt | input | 2 | Frame format select |
| cfg_inv | input | 1 | Line polarity inversion |
| cfg_addr_en | input | 1 | Ninth-bit address filter enable |
| cfg_isel | input | 2 | Interrupt threshold select |
| rd_en | input | 1 | Pop the head character |
| clr_ovf | input | 1 | Clear the overrun flag |
| rd_data | output | 9 | Head character |
| rd_perr | output | 1 | Parity error of head character |
| rd_ferr | output | 1 | Framing error of head character |
| data_avail | output | 1 | Queue non-empty |
| ovf | output | 1 | Sticky overrun |
| idle | output | 1 | No frame in progress |
| irq | output | 1 | Fill-threshold interrupt |

## Verification
A store from a completing frame and a pop from the read port can land on the same clock edge. With a full queue, the result of that edge decides whether an overrun is raised. The bench fills the queue to four and then asserts `rd_en` exactly on the stop-bit decision edge of the next frame, which it computes from its own tick count. The behavioural queue model handles the pop before the push on that edge. It expects no overrun, a fill level that stays at four, and a head that advances by one. The same model then checks that later frames without a pop set `ovf` and are dropped until `clr_ovf`.

// File: rtl/uart_rx_addr.sv
module uart_rx_addr #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick,
  input  logic       cfg_fast,
  input  logic [1:0] cfg_fmt,
  input  logic       cfg_inv,
  input  logic       cfg_addr_en,
  input  logic [1:0] cfg_isel,
  input  logic       rd_en,
  input  logic       clr_ovf,
  output logic [8:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       data_avail,
  output logic       ovf,
  output logic       idle,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic s1, s2, busy, v0, v1, pbit;
  logic [3:0] tcnt, bitn;
  logic [8:0] sh;

  wire       nine     = cfg_fmt == 2'b11;
  wire       has_par  = cfg_fmt == 2'b01 || cfg_fmt == 2'b10;
  wire [3:0] nd       = nine ? 4'd9 : 4'd8;
  wire [3:0] last_bit = nd + {3'b000, has_par} + 4'd1;
  wire       dec      = cfg_fast ? tcnt == 4'd2 : tcnt == 4'd9;
  wire       wrap     = cfg_fast ? tcnt == 4'd3 : tcnt == 4'd15;
  wire       maj      = cfg_fast ? s2 : (v0 & v1) | (v0 & s2) | (v1 & s2);
  wire       done     = busy & tick & dec & bitn == last_bit;
  wire [8:0] word     = nine ? sh : {1'b0, sh[8:1]};
  wire       perr_w   = has_par & (^sh[8:1] ^ pbit ^ cfg_fmt[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_in ^ cfg_inv;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
      bitn <= '0;
      v0   <= 1'b0;
      v1   <= 1'b0;
      pbit <= 1'b0;
      sh   <= '0;
    end else if (tick) begin
      if (!busy) begin
        if (!s2) begin
          busy <= 1'b1;
          tcnt <= 4'd1;
          bitn <= '0;
        end
      end else begin
        tcnt <= wrap ? 4'd0 : tcnt + 4'd1;
        if (wrap) bitn <= bitn + 4'd1;
        if (tcnt == 4'd7) v0 <= s2;
        if (tcnt == 4'd8) v1 <= s2;
        if (dec) begin
          if (bitn == 4'd0) begin
            if (maj) busy <= 1'b0;
          end else if (bitn <= nd) sh <= {maj, sh[8:1]};
          else if (bitn == last_bit) busy <= 1'b0;
          else pbit <= maj;
        end
      end
    end

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire accept  = !(nine & cfg_addr_en & !word[8]);
  wire full    = cnt == CW'(DEPTH);
  wire pop     = rd_en & (cnt != '0);
  wire push    = done & accept & !ovf & (!full | pop);
  wire ovf_set = done & accept & !ovf & full & !pop;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {!maj, perr_w, word};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      if (push && !pop) cnt <= cnt + CW'(1);
      else if (!push && pop) cnt <= cnt - CW'(1);
      ovf <= clr_ovf ? 1'b0 : (ovf | ovf_set);
    end

  assign {rd_ferr, rd_perr, rd_data} = mem[rp];
  assign data_avail = cnt != '0;
  assign idle       = !busy;

  always_comb
    case (cfg_isel)
      2'b10:   irq = cnt >= CW'(DEPTH - 1);
      2'b11:   irq = full;
      default: irq = cnt != '0;
    endcase
endmodule

// File: rtl/uart_rx_addr_chk.sv
module uart_rx_addr_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          idle,
  input logic          data_avail,
  input logic          ovf,
  input logic          clr_ovf,
  input logic          rd_en,
  input logic          cfg_addr_en,
  input logic          irq,
  input logic [1:0]    cfg_fmt,
  input logic [1:0]    cfg_isel,
  input logic [8:0]    rd_data,
  input logic [CW-1:0] cnt
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ovf |=> ovf); // R7
  AST_OVF_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !rd_en |=> cnt == $past(cnt)); // R7
  AST_IDLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !tick |=> idle); // R12
  AST_STORE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> $past(!idle)); // R5
  AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) && cfg_fmt == 2'b11 && cfg_addr_en |-> rd_data[8]); // R9
  AST_FULL_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_isel == 2'b11 && irq && !rd_en |=> irq || cfg_isel != 2'b11); // R8
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R5
endmodule

bind uart_rx_addr uart_rx_addr_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .idle(idle), .data_avail(data_avail),
  .ovf(ovf), .clr_ovf(clr_ovf), .rd_en(rd_en), .cfg_addr_en(cfg_addr_en),
  .irq(irq), .cfg_fmt(cfg_fmt), .cfg_isel(cfg_isel), .rd_data(rd_data), .cnt(cnt)
);

// File: tb/tb_uart_rx_addr.sv
module tb_uart_rx_addr;
  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, tick;
  logic cfg_fast = 1'b0, cfg_inv = 1'b0, cfg_addr_en = 1'b0;
  logic [1:0] cfg_fmt = 2'b00, cfg_isel = 2'b00;
  logic rd_en = 1'b0, clr_ovf = 1'b0;
  logic [8:0] rd_data;
  logic rd_perr, rd_ferr, data_avail, ovf, idle, irq;

  int P = 1, ecnt = 0, n_chk = 0, n_fail = 0;
  bit done_flag = 0, run_cmp = 0;

  always #10 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;
  assign tick = (ecnt % P) == 0;

  uart_rx_addr dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick), .cfg_fast(cfg_fast),
    .cfg_fmt(cfg_fmt), .cfg_inv(cfg_inv), .cfg_addr_en(cfg_addr_en),
    .cfg_isel(cfg_isel), .rd_en(rd_en), .clr_ovf(clr_ovf), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .data_avail(data_avail), .ovf(ovf),
    .idle(idle), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [10:0] m_q[$];
  bit m_ovf = 0, m_idle = 1;
  bit ev_start = 0, ev_end = 0, ev_done = 0, ev_acc = 0;
  logic [10:0] ev_word = '0;

  always @(posedge clk) begin
    bit pop, full, ovs;
    if (!rst_n) begin
      m_q.delete();
      m_ovf = 0;
      m_idle = 1;
    end else begin
      full = m_q.size() == 4;
      pop = rd_en && m_q.size() > 0;
      ovs = 0;
      if (ev_start) m_idle = 0;
      if (ev_end) m_idle = 1;
      if (pop) void'(m_q.pop_front());
      if (ev_done && ev_acc && !m_ovf) begin
        if (!full || pop) m_q.push_back(ev_word);
        else ovs = 1;
      end
      m_ovf = clr_ovf ? 0 : (m_ovf | ovs);
    end
  end

  function automatic bit m_irq();
    case (cfg_isel)
      2'b10:   return m_q.size() >= 3;
      2'b11:   return m_q.size() == 4;
      default: return m_q.size() > 0;
    endcase
  endfunction

  always @(negedge clk) if (run_cmp) begin
    bit av;
    av = m_q.size() > 0;
    chk(data_avail === av, "R5", "data_avail", int'(data_avail), int'(av));
    if (av) begin
      chk(rd_data === m_q[0][8:0], "R5", "rd_data", int'(rd_data), int'(m_q[0][8:0]));
      chk(rd_perr === m_q[0][9], "R3", "rd_perr", int'(rd_perr), int'(m_q[0][9]));
      chk(rd_ferr === m_q[0][10], "R4", "rd_ferr", int'(rd_ferr), int'(m_q[0][10]));
    end
    chk(ovf === m_ovf, "R7", "ovf", int'(ovf), int'(m_ovf));
    chk(idle === m_idle, "R11", "idle", int'(idle), int'(m_idle));
    chk(irq === m_irq(), "R8", "irq", int'(irq), int'(m_irq()));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic align();
    while ((ecnt + 2) % P != 0) step(1);
  endtask

  task automatic send(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                      input int glitch_bit, input bit rd_at_end);
    bit nine, hp, pb;
    int nd, nb, osr, dc, k;
    logic bits [12];
    nine = cfg_fmt == 2'b11;
    hp = cfg_fmt == 2'b01 || cfg_fmt == 2'b10;
    nd = nine ? 9 : 8;
    nb = nd + (hp ? 1 : 0) + 2;
    osr = cfg_fast ? 4 : 16;
    dc = cfg_fast ? 2 : 9;
    bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) bits[1 + i] = d[i];
    pb = (^d[7:0]) ^ cfg_fmt[1] ^ bad_par;
    if (hp) bits[nd + 1] = pb;
    bits[nb - 1] = 1'b1;
    k = P * ((nb - 1) * osr + dc);
    align();
    fork
      begin
        for (int b = 0; b < nb; b++)
          for (int t = 0; t < osr * P; t++) begin
            logic v;
            v = bits[b];
            if (b == glitch_bit && t >= 8 * P && t < 9 * P) v = !v;
            if (b == nb - 1 && bad_stop && t < (dc + 1) * P) v = 1'b0;
            rx_in = v ^ cfg_inv;
            step(1);
          end
      end
      begin
        step(2);
        ev_start = 1;
        step(1);
        ev_start = 0;
        step(k - 1);
        ev_done = 1;
        ev_end = 1;
        ev_acc = !(nine && cfg_addr_en && !d[8]);
        ev_word = {bad_stop, hp && bad_par, nine ? d : {1'b0, d[7:0]}};
        if (rd_at_end) rd_en = 1;
        step(1);
        ev_done = 0;
        ev_end = 0;
        rd_en = 0;
      end
    join
  endtask

  task automatic false_start();
    align();
    fork
      begin
        rx_in = cfg_inv;
        step(4 * P);
        rx_in = !cfg_inv;
        step(16 * P);
      end
      begin
        step(2);
        ev_start = 1;
        step(1);
        ev_start = 0;
        step(P * 9 - 1);
        ev_end = 1;
        step(1);
        ev_end = 0;
      end
    join
  endtask

  task automatic pop();
    rd_en = 1;
    step(1);
    rd_en = 0;
  endtask

  task automatic expect_head(input logic [8:0] w, input bit pe, input bit fe, input string tag);
    chk(data_avail === 1'b1, tag, "head present", int'(data_avail), 1);
    chk(rd_data === w, tag, "head data", int'(rd_data), int'(w));
    chk(rd_perr === pe, tag, "head parity flag", int'(rd_perr), int'(pe));
    chk(rd_ferr === fe, tag, "head framing flag", int'(rd_ferr), int'(fe));
    pop();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 150000);
    chk(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    step(5);
    rst_n = 1;
    step(1);
    chk(idle === 1'b1, "R11", "reset idle", int'(idle), 1);
    chk(data_avail === 1'b0, "R5", "reset empty", int'(data_avail), 0);
    chk(ovf === 1'b0, "R7", "reset ovf", int'(ovf), 0);
    chk(irq === 1'b0, "R8", "reset irq", int'(irq), 0);
    run_cmp = 1;

    send(9'h0A5, 0, 0, -1, 0);                  // R1 R2 plain 8-bit
    expect_head(9'h0A5, 0, 0, "R2");
    send(9'h03C, 0, 0, 3, 0);                   // R1 one-tick glitch outvoted
    expect_head(9'h03C, 0, 0, "R1");
    false_start();                              // R1 short low pulse
    chk(data_avail === 1'b0, "R1", "false start stored", int'(data_avail), 0);
    chk(idle === 1'b1, "R11", "idle after false start", int'(idle), 1);

    cfg_fmt = 2'b01; step(3);                   // R3 even parity
    send(9'h096, 0, 0, -1, 0);
    send(9'h096, 1, 0, -1, 0);
    expect_head(9'h096, 0, 0, "R3");
    expect_head(9'h096, 1, 0, "R3");
    cfg_fmt = 2'b10; step(3);                   // R3 odd parity
    send(9'h001, 0, 0, -1, 0);
    send(9'h001, 1, 0, -1, 0);
    expect_head(9'h001, 0, 0, "R3");
    expect_head(9'h001, 1, 0, "R3");

    cfg_fmt = 2'b00; step(3);                   // R4 framing
    send(9'h055, 0, 1, -1, 0);
    expect_head(9'h055, 0, 1, "R4");

    cfg_fast = 1; step(3);                      // R1 4x mode
    send(9'h0C3, 0, 0, -1, 0);
    expect_head(9'h0C3, 0, 0, "R1");
    cfg_fast = 0; P = 3; step(3);               // R12 sparse ticks
    send(9'h05A, 0, 0, -1, 0);
    expect_head(9'h05A, 0, 0, "R12");
    P = 1; step(3);

    cfg_isel = 2'b10; step(1);                  // R8 thresholds, R5 R6 R7
    send(9'h011, 0, 0, -1, 0);
    send(9'h022, 0, 0, -1, 0);
    chk(irq === 1'b0, "R8", "irq at 2 of 3", int'(irq), 0);
    send(9'h033, 0, 0, -1, 0);
    chk(irq === 1'b1, "R8", "irq at 3 of 3", int'(irq), 1);
    cfg_isel = 2'b11; step(1);
    chk(irq === 1'b0, "R8", "irq at 3 of 4", int'(irq), 0);
    send(9'h044, 0, 0, -1, 0);
    chk(irq === 1'b1, "R8", "irq at 4 of 4", int'(irq), 1);
    send(9'h055, 0, 0, -1, 1);                  // R6 push and pop on one edge
    chk(ovf === 1'b0, "R6", "ovf after same-edge pop", int'(ovf), 0);
    chk(rd_data === 9'h022, "R6", "head advanced", int'(rd_data), 'h22);
    chk(irq === 1'b1, "R6", "still full", int'(irq), 1);
    send(9'h066, 0, 0, -1, 0);                  // R7 overrun
    chk(ovf === 1'b1, "R7", "ovf set", int'(ovf), 1);
    pop();
    send(9'h077, 0, 0, -1, 0);
    chk(ovf === 1'b1, "R7", "ovf sticky", int'(ovf), 1);
    chk(irq === 1'b0, "R7", "blocked char not stored", int'(irq), 0);
    clr_ovf = 1; step(1); clr_ovf = 0;
    send(9'h088, 0, 0, -1, 0);
    chk(ovf === 1'b0, "R7", "ovf cleared", int'(ovf), 0);
    chk(irq === 1'b1, "R7", "store resumes", int'(irq), 1);
    expect_head(9'h033, 0, 0, "R5");
    expect_head(9'h044, 0, 0, "R5");
    expect_head(9'h055, 0, 0, "R5");
    expect_head(9'h088, 0, 0, "R5");
    cfg_isel = 2'b00; step(1);

    cfg_fmt = 2'b11; cfg_addr_en = 1; step(3);  // R9 address filter
    send(9'h012, 0, 0, -1, 0);
    chk(data_avail === 1'b0, "R9", "data char discarded", int'(data_avail), 0);
    send(9'h1A7, 0, 0, -1, 0);
    expect_head(9'h1A7, 0, 0, "R9");
    cfg_addr_en = 0; step(3);
    send(9'h034, 0, 0, -1, 0);
    expect_head(9'h034, 0, 0, "R9");

    cfg_fmt = 2'b00; cfg_inv = 1; rx_in = 0; step(5);  // R10 inverted line
    chk(idle === 1'b1, "R10", "low line idles", int'(idle), 1);
    send(9'h081, 0, 0, -1, 0);
    expect_head(9'h081, 0, 0, "R10");
    cfg_inv = 0; rx_in = 1; step(5);

    run_cmp = 0;
    finish_run();
  end
endmodule